// File: doc/BRIEF.md
# Indirect Address Gather Engine

This block fetches three external words whose bus addresses are not given directly. They are stored in one row of an internal register memory. When enabled, the engine reads that 96-bit row once and splits it into three 32-bit pointer slots, named X, Y and Z. It then runs one single-beat read on a Wishbone-style master port for each slot, in turn. Each returned word is written back into the internal memory. The three words land at three consecutive addresses, starting from a base address.

A controller raises `en` with the row address and the base address on the pins and then waits for `done`. Both addresses are sampled on the clock edge at which `en` is first seen high. `done` stays high while `en` is held. Lowering `en` at any point aborts the work and rewinds the engine to the X slot. The bus side follows the usual strobe/acknowledge back-pressure rule: the slave may stall for any number of cycles by holding `wb_ack` low, and the engine holds its request unchanged until it sees the acknowledge.

Top module: `ptr_gather`

## Requirements
- R1: Bus reads are issued in slot order X, Y, Z. X is row bits 95:64, Y is bits 63:32 and Z is bits 31:0. Each slot's value is used as `wb_adr`.
- R2: During a bus read, `wb_cyc` and `wb_stb` are high and `wb_we` is low. `wb_adr` is held unchanged until `wb_ack` is sampled high.
- R3: The k-th returned word (k = 0, 1, 2) is written with a one-cycle `mem_wr_en` pulse. The write goes to address base+k, modulo 2^AW, and carries the data returned by the bus.
- R4: A new bus cycle is never started while the internal write of the previous word is in progress. `wb_cyc` is low in every cycle in which `mem_wr_en` is high.
- R5: Exactly one internal row read (`mem_rd_en` for one cycle) is issued per run, at the row address sampled when `en` rose. The read is issued in the first cycle after that edge, and the first bus strobe appears two cycles after that read.
- R6: `done` rises after the third write and stays high while `en` stays high. No further bus cycles or writes happen while `done` is high.
- R7: When `en` is sampled low, any bus cycle in flight is dropped (`wb_cyc` low from the next cycle on), `done` clears, and the next assertion of `en` starts again from the X slot.
- R8: A synchronous reset makes `wb_cyc`, `wb_stb`, `mem_wr_en` and `done` low and returns the engine to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Start and hold; low aborts and rewinds |
| row_addr | input | AW | Internal row that holds the three pointers |
| store_base | input | AW | First internal address for the results |
| mem_rd_en | output | 1 | Internal memory read request (data valid next cycle) |
| mem_rd_addr | output | AW | Internal memory read address |
| mem_rd_data | input | 3*DW | Internal memory read data, one row |
| mem_wr_en | output | 1 | Internal memory write strobe |
| mem_wr_addr | output | AW | Internal memory write address |
| mem_wr_data | output | DW | Internal memory write data |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Bus write enable, always low |
| wb_adr | output | DW | Bus address taken from the current slot |
| wb_dat_i | input | DW | Bus read data |
| wb_ack | input | 1 | Bus acknowledge |
| done | output | 1 | All three words stored |

## Verification
The hardest case to reach from the ports is an abort that lands in the middle of a stalled bus read. The stimulus gives the bus slave a long wait count, drops `en` while the strobe is still waiting for an acknowledge, and checks that the cycle ends and no write appears. It then restarts with a short wait and checks that the first address again comes from the X slot. A base address of all ones makes the three write addresses wrap past zero. Wait counts from zero to several cycles exercise the hold-until-acknowledge rule.

// File: rtl/gath_pkg.sv
package gath_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CAPT,
    ST_BUS,
    ST_WRITE,
    ST_DONE
  } gath_state_e;
endpackage

// File: rtl/gath_slot_sel.sv
// Walking-one slot selector plus row slice multiplexer.
module gath_slot_sel #(
  parameter int DW    = 32,
  parameter int NSLOT = 3,
  localparam int ROW_W = DW * NSLOT,
  localparam int IW    = $clog2(NSLOT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             adv,
  input  logic [ROW_W-1:0] row,
  output logic [NSLOT:0]   sel,
  output logic [DW-1:0]    slot_word,
  output logic [IW-1:0]    idx,
  output logic             last
);
  localparam logic [NSLOT:0] SEL_INIT = {{NSLOT{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || clear)  sel <= SEL_INIT;
    else if (adv)      sel <= {sel[NSLOT-1:0], 1'b0};
  end

  logic [DW-1:0] term [NSLOT];
  for (genvar i = 0; i < NSLOT; i++) begin : g_slice
    // slot 0 (X) sits in the most significant slice
    assign term[i] = sel[i] ? row[ROW_W-1-i*DW -: DW] : '0;
  end

  always_comb begin
    slot_word = '0;
    for (int i = 0; i < NSLOT; i++) slot_word = slot_word | term[i];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i <= NSLOT; i++)
      if (sel[i]) idx = idx | IW'(i);
  end

  assign last = sel[NSLOT-1];
endmodule

// File: rtl/gath_ctrl.sv
// Sequencer: row fetch, per-slot bus read, write-back, done.
module gath_ctrl
  import gath_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ack,
  input  logic last,
  output logic start,
  output logic rd_en,
  output logic capt,
  output logic bus,
  output logic wr,
  output logic fin
);
  gath_state_e st, st_nx;

  always_comb begin
    st_nx = st;
    if (!en) st_nx = ST_IDLE;
    else begin
      unique case (st)
        ST_IDLE:  st_nx = ST_FETCH;
        ST_FETCH: st_nx = ST_CAPT;
        ST_CAPT:  st_nx = ST_BUS;
        ST_BUS:   st_nx = ack ? ST_WRITE : ST_BUS;
        ST_WRITE: st_nx = last ? ST_DONE : ST_BUS;
        ST_DONE:  st_nx = ST_DONE;
        default:  st_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nx;
  end

  assign start = (st == ST_IDLE) && en;
  assign rd_en = (st == ST_FETCH);
  assign capt  = (st == ST_CAPT);
  assign bus   = (st == ST_BUS);
  assign wr    = (st == ST_WRITE);
  assign fin   = (st == ST_DONE);
endmodule

// File: rtl/ptr_gather.sv
module ptr_gather #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int NSLOT = 3,
  localparam int ROW_W = DW * NSLOT,
  localparam int IW    = $clog2(NSLOT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [AW-1:0]    row_addr,
  input  logic [AW-1:0]    store_base,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic [ROW_W-1:0] mem_rd_data,
  output logic             mem_wr_en,
  output logic [AW-1:0]    mem_wr_addr,
  output logic [DW-1:0]    mem_wr_data,
  output logic             wb_cyc,
  output logic             wb_stb,
  output logic             wb_we,
  output logic [DW-1:0]    wb_adr,
  input  logic [DW-1:0]    wb_dat_i,
  input  logic             wb_ack,
  output logic             done
);
  logic st_start, st_rd, st_capt, st_bus, st_wr, st_fin;
  logic [NSLOT:0] sel_q;
  logic [DW-1:0]  slot_word;
  logic [IW-1:0]  idx;
  logic           last;

  logic [ROW_W-1:0] row_q;
  logic [DW-1:0]    word_q;
  logic [AW-1:0]    base_q, raddr_q;

  gath_ctrl u_ctrl (
    .clk(clk), .rst(rst), .en(en), .ack(wb_ack), .last(last),
    .start(st_start), .rd_en(st_rd), .capt(st_capt), .bus(st_bus),
    .wr(st_wr), .fin(st_fin)
  );

  gath_slot_sel #(.DW(DW), .NSLOT(NSLOT)) u_sel (
    .clk(clk), .rst(rst), .clear(!en), .adv(st_wr), .row(row_q),
    .sel(sel_q), .slot_word(slot_word), .idx(idx), .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q   <= '0;
      word_q  <= '0;
      base_q  <= '0;
      raddr_q <= '0;
    end else begin
      if (st_start) begin
        base_q  <= store_base;
        raddr_q <= row_addr;
      end
      if (st_capt)          row_q  <= mem_rd_data;
      if (st_bus && wb_ack) word_q <= wb_dat_i;
    end
  end

  assign mem_rd_en   = st_rd;
  assign mem_rd_addr = raddr_q;
  assign mem_wr_en   = st_wr;
  assign mem_wr_addr = base_q + AW'(idx);
  assign mem_wr_data = word_q;
  assign wb_cyc      = st_bus;
  assign wb_stb      = st_bus;
  assign wb_we       = 1'b0;
  assign wb_adr      = slot_word;
  assign done        = st_fin;
endmodule

// File: rtl/gath_chk.sv
module gath_chk #(
  parameter int DW    = 32,
  parameter int NSLOT = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input logic           wb_cyc,
  input logic           wb_stb,
  input logic           wb_we,
  input logic [DW-1:0]  wb_adr,
  input logic           wb_ack,
  input logic           mem_wr_en,
  input logic           done,
  input logic [NSLOT:0] sel
);
  assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(sel) == 1);
  assert_read_only_R2: assert property (@(posedge clk) disable iff (rst)
    wb_cyc |-> !wb_we);
  assert_hold_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (wb_stb && !wb_ack && en) |=> (wb_stb && $stable(wb_adr)));
  assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |=> !mem_wr_en);
  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> !wb_cyc);
  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (sel[NSLOT] && !wb_cyc && !mem_wr_en));
  assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!wb_cyc && !done));
  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (!wb_cyc && !wb_stb && !mem_wr_en && !done));
endmodule

bind ptr_gather gath_chk #(.DW(DW), .NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst(rst), .en(en), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
  .wb_we(wb_we), .wb_adr(wb_adr), .wb_ack(wb_ack), .mem_wr_en(mem_wr_en),
  .done(done), .sel(sel_q)
);

// File: tb/ptr_gather_tb.sv
module ptr_gather_tb;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [AW-1:0] row_addr = '0, store_base = '0;
  logic mem_rd_en, mem_wr_en, wb_cyc, wb_stb, wb_we, done;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [3*DW-1:0] mem_rd_data = '0;
  logic [DW-1:0] mem_wr_data, wb_adr;
  logic [DW-1:0] wb_dat_i = '0;
  logic wb_ack = 1'b0;

  always #4 clk = ~clk;

  ptr_gather u_dut (
    .clk(clk), .rst(rst), .en(en), .row_addr(row_addr), .store_base(store_base),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat_i(wb_dat_i), .wb_ack(wb_ack), .done(done)
  );

  int total = 0, bad = 0;
  int wait_n = 0, wcnt = 0;
  int cyc_n = 0, first_stb = -1, rd_cnt = 0, viol = 0, nlog = 0;
  logic [AW-1:0] rd_seen;
  logic [AW-1:0] log_a [8];
  logic [DW-1:0] log_d [8];
  logic [3*DW-1:0] mem [256];

  function automatic logic [DW-1:0] resp(input logic [DW-1:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory and bus slave models, driven between edges
  initial forever begin
    @(negedge clk);
    if (mem_rd_en) mem_rd_data = mem[mem_rd_addr];
    if (wb_cyc && wb_stb) begin
      if (wcnt >= wait_n) begin wb_ack = 1'b1; wb_dat_i = resp(wb_adr); end
      else begin wb_ack = 1'b0; wcnt++; end
    end else begin
      wb_ack = 1'b0; wcnt = 0;
    end
  end

  // observer, samples shortly after each rising edge
  initial forever begin
    @(posedge clk); #2;
    cyc_n++;
    if (wb_stb && first_stb < 0) first_stb = cyc_n;
    if (mem_rd_en) begin rd_cnt++; rd_seen = mem_rd_addr; end
    if (wb_cyc && wb_we) viol++;
    if (mem_wr_en && wb_cyc) viol++;
    if (mem_wr_en && nlog < 8) begin
      log_a[nlog] = mem_wr_addr; log_d[nlog] = mem_wr_data; nlog++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic clear_obs();
    nlog = 0; rd_cnt = 0; first_stb = -1; viol = 0;
  endtask

  task automatic begin_run(input logic [AW-1:0] ra, input logic [AW-1:0] ba,
                           input logic [DW-1:0] x, input logic [DW-1:0] y,
                           input logic [DW-1:0] z, input int w, output int st);
    mem[ra] = {x, y, z};
    wait_n = w;
    @(negedge clk);
    row_addr = ra; store_base = ba;
    clear_obs();
    en = 1'b1;
    st = cyc_n;
  endtask

  task automatic finish_run(input logic [AW-1:0] ra, input logic [AW-1:0] ba,
                            input logic [DW-1:0] x, input logic [DW-1:0] y,
                            input logic [DW-1:0] z, input int st);
    logic [DW-1:0] exp_w [3];
    exp_w[0] = resp(x); exp_w[1] = resp(y); exp_w[2] = resp(z);
    for (int t = 0; t < 300 && !done; t++) @(negedge clk);
    chk(done == 1'b1, "R6 done raised", done, 1);
    chk(nlog == 3, "R3 write count", nlog, 3);
    for (int k = 0; k < 3; k++) begin
      chk(log_a[k] == AW'(ba + AW'(k)), "R3 write address", log_a[k], AW'(ba + AW'(k)));
      chk(log_d[k] == exp_w[k], "R1 slot order / returned data", log_d[k], exp_w[k]);
    end
    chk(rd_cnt == 1 && rd_seen == ra, "R5 single row read", rd_seen, ra);
    chk(first_stb - st == 3, "R5 first strobe timing", first_stb - st, 3);
    chk(viol == 0, "R2 R4 bus protocol", viol, 0);
  endtask

  // row, base, x, y, z, wait
  localparam int NV = 4;
  localparam logic [8+8+32*3+8-1:0] VEC [NV] = '{
    {8'h10, 8'h40, 32'h1000_0004, 32'h2000_0008, 32'h3000_000C, 8'd0},
    {8'h22, 8'h80, 32'hDEAD_0000, 32'h0000_BEEF, 32'hFFFF_FFFF, 8'd3},
    {8'h05, 8'hFF, 32'h0000_0001, 32'h8000_0000, 32'h1234_5678, 8'd1},
    {8'hFE, 8'h00, 32'hAAAA_5555, 32'hAAAA_5555, 32'h0F0F_F0F0, 8'd6}
  };

  initial begin
    int st;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!wb_cyc && !wb_stb && !mem_wr_en && !done, "R8 reset state",
        {wb_cyc, wb_stb, mem_wr_en, done}, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [AW-1:0] ra, ba;
      logic [DW-1:0] x, y, z;
      {ra, ba, x, y, z} = VEC[v][8+8+96+8-1:8];
      begin_run(ra, ba, x, y, z, int'(VEC[v][7:0]), st);
      finish_run(ra, ba, x, y, z, st);
      @(negedge clk); en = 1'b0;
      repeat (2) @(negedge clk);
    end

    // R6: done holds while en stays high, no extra activity
    begin_run(8'h33, 8'h20, 32'h11, 32'h22, 32'h33, 2, st);
    finish_run(8'h33, 8'h20, 32'h11, 32'h22, 32'h33, st);
    repeat (6) @(negedge clk);
    chk(done == 1'b1, "R6 done held", done, 1);
    chk(nlog == 3 && !wb_cyc, "R6 quiet after done", nlog, 3);
    en = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R7 done clears on en low", done, 0);

    // R7: abort during stalled bus read, then restart from X
    begin_run(8'h44, 8'h60, 32'hCAFE_0001, 32'hCAFE_0002, 32'hCAFE_0003, 20, st);
    repeat (6) @(negedge clk);
    chk(wb_stb == 1'b1, "R2 strobe held while stalled", wb_stb, 1);
    en = 1'b0;
    @(negedge clk);
    chk(wb_cyc == 1'b0, "R7 abort drops cycle", wb_cyc, 0);
    repeat (3) @(negedge clk);
    chk(nlog == 0, "R7 no write after abort", nlog, 0);
    begin_run(8'h44, 8'h60, 32'hCAFE_0001, 32'hCAFE_0002, 32'hCAFE_0003, 1, st);
    repeat (3) @(negedge clk);
    chk(wb_adr == 32'hCAFE_0001, "R7 restart from X slot", wb_adr, 32'hCAFE_0001);
    finish_run(8'h44, 8'h60, 32'hCAFE_0001, 32'hCAFE_0002, 32'hCAFE_0003, st);
    en = 1'b0;
    repeat (2) @(negedge clk);

    // R8: reset in the middle of a run
    begin_run(8'h55, 8'h10, 32'h1, 32'h2, 32'h3, 10, st);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!wb_cyc && !wb_stb && !mem_wr_en && !done, "R8 reset mid-run",
        {wb_cyc, wb_stb, mem_wr_en, done}, 0);
    en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule